// File: doc/BRIEF.md
# Signed/Unsigned Restoring Integer Divider

This block divides one WIDTH-bit integer by another over several clock cycles. It produces a quotient and a remainder. Operands are read as unsigned values, or as two's complement values when `signed_mode` is high. The divider works on magnitudes. It keeps a partial remainder register one bit wider than the operands, a dividend/quotient register, a divisor register and a step counter. Each cycle it does one shift-and-trial-subtract step and restores the partial remainder whenever the trial result goes negative. After WIDTH steps it applies the sign rules of truncating division to both results.

Operands enter through a valid/ready handshake. An operation is accepted in a cycle where `in_valid` and `in_ready` are both high. `in_ready` is low while a division is in progress, which provides the back-pressure. A request presented while `in_ready` is low is not taken, and the source keeps it presented or drops it as it chooses. Results come out on plain pins, together with a one-cycle `done` pulse. They stay unchanged until the next completion, so a consumer can read them at any later time.

A zero divisor takes a short path. No iteration runs. The flag is raised, the quotient is set to all ones and the remainder is set to the dividend.

Top module: `div_restoring_top`

## Requirements
- R1: While reset is active and in the first cycle after it, `in_ready` is 1, and `done`, `div_by_zero`, `quotient` and `remainder` are all 0.
- R2: An operation is accepted only in a cycle with `in_valid` and `in_ready` both high. After a nonzero divisor is accepted, `in_ready` stays 0 until the cycle in which `done` is high. Requests presented while `in_ready` is 0 have no effect on the results.
- R3: For a nonzero divisor, `done` is high in the WIDTH+1-th cycle after the acceptance cycle.
- R4: In unsigned mode (`signed_mode`=0), `quotient` is the dividend divided by the divisor rounded down, and `remainder` is the dividend modulo the divisor. For example, 7/3 with WIDTH=4 gives quotient 0010 and remainder 0001.
- R5: In signed mode (`signed_mode`=1), the operands are two's complement and division truncates toward zero. The quotient is negated when exactly one operand is negative. The remainder takes the dividend's sign. For example: 7/-3 gives -2 r 1, -7/3 gives -2 r -1, and -7/-3 gives 2 r -1.
- R6: In signed mode, the most negative value divided by -1 gives a quotient equal to the most negative value (wrap modulo 2^WIDTH) and a remainder of 0.
- R7: For every nonzero divisor in either mode, quotient × divisor + remainder equals the dividend modulo 2^WIDTH.
- R8: A zero divisor raises `done` and `div_by_zero` in the cycle right after acceptance, in either mode. In that case `quotient` is all ones and `remainder` equals the dividend.
- R9: `quotient`, `remainder` and `div_by_zero` change only in a cycle where `done` is high. `div_by_zero` is 0 after any completion with a nonzero divisor.
- R10: `done` lasts a single cycle unless a zero-divisor request is accepted in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand request valid |
| in_ready | output | 1 | Divider idle and able to accept |
| dividend | input | WIDTH | Dividend operand |
| divisor | input | WIDTH | Divisor operand |
| signed_mode | input | 1 | 1: two's complement operands, 0: unsigned |
| quotient | output | WIDTH | Quotient of the last completed operation |
| remainder | output | WIDTH | Remainder of the last completed operation |
| div_by_zero | output | 1 | Last completed operation had a zero divisor |
| done | output | 1 | One-cycle completion pulse |

## Verification
A wrong restore decision or a lost quotient bit corrupts the quotient or remainder of that same operation. It shows up WIDTH+1 cycles after acceptance, at the `done` pulse, and it breaks the division identity. A miscounted step counter moves the `done` pulse or holds `in_ready` low too long, and this is visible in the first operation after reset. A wrong sign flag only affects signed cases with mixed-sign operands or a negative dividend, so every sign combination and every operand pair at WIDTH=4 is swept in both modes.

// File: rtl/div_pkg.sv
package div_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } div_state_e;

  function automatic int unsigned cnt_bits(input int unsigned steps);
    return (steps < 2) ? 1 : $clog2(steps + 1);
  endfunction

endpackage

// File: rtl/div_prep.sv
// Operand conditioning: strips the sign in signed mode, passes through otherwise.
module div_prep #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] val,
  input  logic             signed_mode,
  output logic [WIDTH-1:0] mag,
  output logic             neg
);

  always_comb begin
    neg = signed_mode & val[WIDTH-1];
    if (neg) begin
      mag = (~val) + WIDTH'(1);
    end else begin
      mag = val;
    end
  end

endmodule

// File: rtl/div_step.sv
// One restoring iteration: shift {A,Q} left, trial subtract, keep or restore.
module div_step #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH:0]   a_in,
  input  logic [WIDTH-1:0] q_in,
  input  logic [WIDTH-1:0] m_in,
  output logic [WIDTH:0]   a_out,
  output logic [WIDTH-1:0] q_out
);

  logic [WIDTH:0] a_shift;
  logic [WIDTH:0] trial;
  logic           went_neg;

  always_comb begin
    a_shift  = {a_in[WIDTH-1:0], q_in[WIDTH-1]};
    trial    = a_shift - {1'b0, m_in};
    went_neg = trial[WIDTH];
    if (went_neg) begin
      a_out = a_shift;
      q_out = {q_in[WIDTH-2:0], 1'b0};
    end else begin
      a_out = trial;
      q_out = {q_in[WIDTH-2:0], 1'b1};
    end
  end

endmodule

// File: rtl/div_fix.sv
// Result sign correction after magnitude division.
module div_fix #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] q_mag,
  input  logic [WIDTH-1:0] r_mag,
  input  logic             neg_q,
  input  logic             neg_r,
  output logic [WIDTH-1:0] q_res,
  output logic [WIDTH-1:0] r_res
);

  always_comb begin
    q_res = neg_q ? ((~q_mag) + WIDTH'(1)) : q_mag;
    r_res = neg_r ? ((~r_mag) + WIDTH'(1)) : r_mag;
  end

endmodule

// File: rtl/div_restoring_top.sv
module div_restoring_top #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  input  logic             signed_mode,
  output logic [WIDTH-1:0] quotient,
  output logic [WIDTH-1:0] remainder,
  output logic             div_by_zero,
  output logic             done
);

  import div_pkg::*;

  localparam int CW = cnt_bits(WIDTH);

  div_state_e       state_q;
  logic [WIDTH:0]   acc_q;
  logic [WIDTH-1:0] quo_q;
  logic [WIDTH-1:0] dsr_q;
  logic [CW-1:0]    steps_q;
  logic             neg_quo_q;
  logic             neg_rem_q;

  logic [WIDTH-1:0] quo_r;
  logic [WIDTH-1:0] rem_r;
  logic             dbz_r;
  logic             done_r;

  logic [WIDTH-1:0] dvd_mag;
  logic [WIDTH-1:0] dsr_mag;
  logic             dvd_neg;
  logic             dsr_neg;
  logic [WIDTH:0]   acc_nxt;
  logic [WIDTH-1:0] quo_nxt;
  logic [WIDTH-1:0] q_fixed;
  logic [WIDTH-1:0] r_fixed;
  logic             accept;
  logic             zero_dsr;
  logic             last_step;

  div_prep #(.WIDTH(WIDTH)) i_prep_dvd (
    .val         (dividend),
    .signed_mode (signed_mode),
    .mag         (dvd_mag),
    .neg         (dvd_neg)
  );

  div_prep #(.WIDTH(WIDTH)) i_prep_dsr (
    .val         (divisor),
    .signed_mode (signed_mode),
    .mag         (dsr_mag),
    .neg         (dsr_neg)
  );

  div_step #(.WIDTH(WIDTH)) i_step (
    .a_in  (acc_q),
    .q_in  (quo_q),
    .m_in  (dsr_q),
    .a_out (acc_nxt),
    .q_out (quo_nxt)
  );

  div_fix #(.WIDTH(WIDTH)) i_fix (
    .q_mag (quo_nxt),
    .r_mag (acc_nxt[WIDTH-1:0]),
    .neg_q (neg_quo_q),
    .neg_r (neg_rem_q),
    .q_res (q_fixed),
    .r_res (r_fixed)
  );

  assign in_ready  = (state_q == ST_IDLE);
  assign accept    = in_valid & in_ready;
  assign zero_dsr  = (divisor == '0);
  assign last_step = (steps_q == CW'(1));

  // Iteration datapath and control.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      acc_q     <= '0;
      quo_q     <= '0;
      dsr_q     <= '0;
      steps_q   <= '0;
      neg_quo_q <= 1'b0;
      neg_rem_q <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (accept && !zero_dsr) begin
            state_q   <= ST_RUN;
            acc_q     <= '0;
            quo_q     <= dvd_mag;
            dsr_q     <= dsr_mag;
            steps_q   <= CW'(WIDTH);
            neg_quo_q <= dvd_neg ^ dsr_neg;
            neg_rem_q <= dvd_neg;
          end
        end
        ST_RUN: begin
          acc_q   <= acc_nxt;
          quo_q   <= quo_nxt;
          steps_q <= steps_q - CW'(1);
          if (last_step) begin
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // Result registers: written only on completion.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quo_r  <= '0;
      rem_r  <= '0;
      dbz_r  <= 1'b0;
      done_r <= 1'b0;
    end else begin
      done_r <= 1'b0;
      if (accept && zero_dsr) begin
        quo_r  <= '1;
        rem_r  <= dividend;
        dbz_r  <= 1'b1;
        done_r <= 1'b1;
      end else if ((state_q == ST_RUN) && last_step) begin
        quo_r  <= q_fixed;
        rem_r  <= r_fixed;
        dbz_r  <= 1'b0;
        done_r <= 1'b1;
      end
    end
  end

  assign quotient    = quo_r;
  assign remainder   = rem_r;
  assign div_by_zero = dbz_r;
  assign done        = done_r;

endmodule

// File: rtl/div_restoring_chk.sv
module div_restoring_chk #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [WIDTH-1:0] dividend,
  input logic [WIDTH-1:0] divisor,
  input logic             signed_mode,
  input logic [WIDTH-1:0] quotient,
  input logic [WIDTH-1:0] remainder,
  input logic             div_by_zero,
  input logic             done
);

  logic             acc_seen;
  logic [15:0]      lat_cnt;
  logic             mode_cap;
  logic [WIDTH-1:0] dsr_cap;

  assign acc_seen = in_valid & in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_cnt  <= '0;
      mode_cap <= 1'b0;
      dsr_cap  <= '0;
    end else if (acc_seen) begin
      lat_cnt  <= '0;
      mode_cap <= signed_mode;
      dsr_cap  <= divisor;
    end else if (lat_cnt != 16'hFFFF) begin
      lat_cnt <= lat_cnt + 16'd1;
    end
  end

  AST_READY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> in_ready); // R2

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_seen && divisor != '0) |=> (!in_ready && !done)); // R2

  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !div_by_zero) |-> (lat_cnt == 16'(WIDTH))); // R3

  AST_UNSIGNED_REM_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !div_by_zero && !mode_cap) |-> (remainder < dsr_cap)); // R4

  AST_ZERO_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_seen && divisor == '0) |=>
      (done && div_by_zero && quotient == {WIDTH{1'b1}} && remainder == $past(dividend))); // R8

  AST_RESULTS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(quotient) && $stable(remainder) && $stable(div_by_zero))); // R9

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !(in_valid && divisor == '0)) |=> !done); // R10

endmodule

bind div_restoring_top div_restoring_chk #(.WIDTH(WIDTH)) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .dividend    (dividend),
  .divisor     (divisor),
  .signed_mode (signed_mode),
  .quotient    (quotient),
  .remainder   (remainder),
  .div_by_zero (div_by_zero),
  .done        (done)
);

// File: tb/test_div_restoring_top.sv
`timescale 1ns/1ps
module test_div_restoring_top;

  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [W-1:0] dividend = '0;
  logic [W-1:0] divisor = '0;
  logic         signed_mode = 1'b0;
  logic [W-1:0] quotient;
  logic [W-1:0] remainder;
  logic         div_by_zero;
  logic         done;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  div_restoring_top #(.WIDTH(W)) i_div_restoring_top (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .dividend    (dividend),
    .divisor     (divisor),
    .signed_mode (signed_mode),
    .quotient    (quotient),
    .remainder   (remainder),
    .div_by_zero (div_by_zero),
    .done        (done)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Drives one request at a negedge; returns at the negedge where done is seen.
  task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b, input logic s,
                        output int lat);
    while (!in_ready) @(negedge clk);
    dividend    = a;
    divisor     = b;
    signed_mode = s;
    in_valid    = 1'b1;
    lat = 0;
    do begin
      @(negedge clk);
      in_valid = 1'b0;
      lat++;
    end while (!done && lat < 50);
  endtask

  task automatic expect_div(input logic [W-1:0] a, input logic [W-1:0] b, input logic s,
                            output logic [W-1:0] eq, output logic [W-1:0] er);
    int qi;
    int ri;
    if (b == '0) begin
      eq = '1;
      er = a;
    end else begin
      if (s) begin
        qi = int'($signed(a)) / int'($signed(b));
        ri = int'($signed(a)) % int'($signed(b));
      end else begin
        qi = int'(a) / int'(b);
        ri = int'(a) % int'(b);
      end
      eq = W'(qi);
      er = W'(ri);
    end
  endtask

  initial begin
    int lat;
    logic [W-1:0] eq;
    logic [W-1:0] er;
    logic [W-1:0] hq;
    logic [W-1:0] hr;
    logic         hz;

    repeat (3) @(negedge clk);
    // R1: reset state
    check(in_ready == 1'b1, "R1 in_ready in reset", int'(in_ready), 1);
    check(done == 1'b0 && div_by_zero == 1'b0, "R1 flags in reset", int'({done, div_by_zero}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(quotient == '0 && remainder == '0, "R1 results after reset",
          int'({quotient, remainder}), 0);
    check(in_ready == 1'b1 && done == 1'b0, "R1 idle after reset", int'({in_ready, done}), 2);

    // R4: worked unsigned example 7/3
    run_op(4'd7, 4'd3, 1'b0, lat);
    check(quotient == 4'b0010, "R4 7/3 quotient", int'(quotient), 2);
    check(remainder == 4'b0001, "R4 7/3 remainder", int'(remainder), 1);

    // R5: signed examples
    run_op(4'd7, 4'b1101, 1'b1, lat);
    check(quotient == 4'b1110 && remainder == 4'b0001, "R5 7/-3",
          int'({quotient, remainder}), int'(8'b1110_0001));
    run_op(4'b1001, 4'd3, 1'b1, lat);
    check(quotient == 4'b1110 && remainder == 4'b1111, "R5 -7/3",
          int'({quotient, remainder}), int'(8'b1110_1111));
    run_op(4'b1001, 4'b1101, 1'b1, lat);
    check(quotient == 4'b0010 && remainder == 4'b1111, "R5 -7/-3",
          int'({quotient, remainder}), int'(8'b0010_1111));

    // R6: most negative / -1
    run_op(4'b1000, 4'b1111, 1'b1, lat);
    check(quotient == 4'b1000 && remainder == 4'b0000, "R6 min/-1",
          int'({quotient, remainder}), int'(8'b1000_0000));

    // R2: request presented while busy is ignored
    @(negedge clk);
    dividend = 4'd13; divisor = 4'd4; signed_mode = 1'b0; in_valid = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b0, "R2 busy after accept", int'(in_ready), 0);
    dividend = 4'd15; divisor = 4'd1;
    lat = 1;
    while (!done && lat < 50) begin
      @(negedge clk);
      lat++;
      if (lat >= 3) in_valid = 1'b0;
    end
    check(quotient == 4'd3 && remainder == 4'd1, "R2 busy request ignored",
          int'({quotient, remainder}), int'(8'h31));
    check(lat == W + 1, "R3 latency busy case", lat, W + 1);
    in_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(in_ready == 1'b1 && done == 1'b0, "R2 idle after ignored request",
          int'({in_ready, done}), 2);

    // Exhaustive sweep in both modes
    for (int s = 0; s < 2; s++) begin
      for (int a = 0; a < (1 << W); a++) begin
        for (int b = 0; b < (1 << W); b++) begin
          run_op(W'(a), W'(b), s[0], lat);
          expect_div(W'(a), W'(b), s[0], eq, er);
          hq = quotient; hr = remainder; hz = div_by_zero;
          if (b == 0) begin
            check(lat == 1, "R8 zero divisor latency", lat, 1);
            check(quotient == eq && remainder == er && div_by_zero == 1'b1,
                  "R8 zero divisor result", int'({div_by_zero, quotient, remainder}),
                  int'({1'b1, eq, er}));
          end else begin
            check(lat == W + 1, "R3 latency", lat, W + 1);
            check(quotient == eq, s ? "R5 signed quotient" : "R4 unsigned quotient",
                  int'(quotient), int'(eq));
            check(remainder == er, s ? "R5 signed remainder" : "R4 unsigned remainder",
                  int'(remainder), int'(er));
            check(div_by_zero == 1'b0, "R9 flag cleared on nonzero", int'(div_by_zero), 0);
            check(W'(int'(quotient) * b + int'(remainder)) == W'(a), "R7 identity",
                  (int'(quotient) * b + int'(remainder)) % (1 << W), a);
          end
          @(negedge clk);
          check(done == 1'b0, "R10 done single cycle", int'(done), 0);
          @(negedge clk);
          check(quotient == hq && remainder == hr && div_by_zero == hz, "R9 results held",
                int'({div_by_zero, quotient, remainder}), int'({hz, hq, hr}));
        end
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule